// File: doc/BRIEF.md
# OSD Dot Clock and Size Generator

This block paces the pixels of one on-screen display character block. The block has two source clocks, a data-slicer clock and an oscillator clock. Each reaches the block as a one-cycle enable in the system clock domain, and the configuration chooses one of them. The chosen enable is pre-divided by 1, 2 or 3. One pre-divided period is the basic dot time unit, called TC here. Each dot is TC multiplied by the horizontal dot size. Each dot row lasts a number of scan lines, and that number doubles in bi-scan mode.

A horizontal sync pulse starts every scan line. At that pulse the block captures the configuration inputs into a shadow copy, and the shadow copy controls the whole line. The block counts enables of the chosen source since sync. When the count reaches the programmed start position, the block waits one more TC. It then raises the display-active flag and pulses the dot strobe for the leftmost dot. A second pulse, the row strobe, marks each sync that ends a dot row. The block flags a configuration that asks for pre-divide ratio 3 in closed-caption mode, and it uses ratio 2 in that case.

Top module: `osd_dot_timing`

## Requirements
- R1: The source select `cfg_src_osc` is captured at sync. The value 0 chooses `ds_clk_en` and the value 1 chooses `osc_clk_en`. The enable of the source that is not chosen has no effect on any output.
- R2: For a layer-1 block, `cfg_prediv` sets the pre-divide ratio: 0 gives 1, 1 gives 2, and 2 or 3 gives 3. One TC is that many enables of the chosen source.
- R3: Enables of the chosen source are counted from 0 after each sync, and an enable in the sync cycle is not counted. The enable that arrives while the count equals `cfg_hstart` is the start. The first TC ends on the ratio-th chosen-source enable after the start. `dot_stb` is high in the cycle after the clock edge that samples that enable.
- R4: For a layer-1 block, each dot lasts `cfg_size_l1[1:0]`+1 TC. `dot_stb` pulses for one cycle at the start of every dot, so it fires on TC numbers 1, 1+n, 1+2n and so on.
- R5: For a layer-1 block, a dot row lasts `cfg_size_l1[3:2]`+1 lines, or twice that when `cfg_biscan` is 1. `line_stb` is high in the cycle after the sync that completes a row. After reset the first row starts at the first sync.
- R6: For a layer-2 block (`cfg_layer2`=1), the ratio comes from the shared bit `cfg_l2_div2`: 0 gives 1 and 1 gives 2. The value `cfg_size_l2`+1 sets both the TC count per dot and the line count per row, and `cfg_biscan` still doubles the row.
- R7: A layer-1 block with `cfg_cc_mode`=1 and `cfg_prediv` equal to 2 or 3 raises `cfg_err` for that line and uses ratio 2.
- R8: The block samples the configuration inputs only in a sync cycle. A change between two syncs has no effect until the next sync.
- R9: After reset all outputs are low. Enables that arrive before the first sync start no display.
- R10: `disp_active` rises in the same cycle as the first `dot_stb` of a line. It stays high until the next sync, and the cycle after that sync shows it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ds_clk_en | input | 1 | One-cycle enable from the data-slicer clock |
| osc_clk_en | input | 1 | One-cycle enable from the oscillator clock |
| hsync | input | 1 | One-cycle horizontal sync pulse |
| cfg_src_osc | input | 1 | Source select: 0 for data slicer, 1 for oscillator |
| cfg_cc_mode | input | 1 | Block is in closed-caption mode |
| cfg_layer2 | input | 1 | Block is on layer 2 |
| cfg_prediv | input | 2 | Layer-1 pre-divide code |
| cfg_size_l1 | input | 4 | Layer-1 dot size: [1:0] horizontal-1, [3:2] vertical-1 |
| cfg_size_l2 | input | 2 | Layer-2 square dot size minus one |
| cfg_l2_div2 | input | 1 | Shared layer-2 ratio bit |
| cfg_biscan | input | 1 | Double the row height |
| cfg_hstart | input | HPOS_W | Start position in chosen-source enables |
| dot_stb | output | 1 | One-cycle pulse at the start of each dot |
| line_stb | output | 1 | One-cycle pulse after the sync that ends a dot row |
| disp_active | output | 1 | The block is displaying on this line |
| cfg_err | output | 1 | Illegal ratio 3 was requested in closed-caption mode |

## Verification
The assertions assume that `hsync` lasts a single cycle and that a line never holds more enables than the start counter can count. They also assume that the configuration seen at sync comes from the legal encodings listed above. The stimulus uses one-cycle sync pulses and lines of at most 60 cycles. It stops both source enables a few cycles before each sync, so every dot of a line is out before the next capture. All configuration changes happen in the cycle that drives sync, except in the line that tests R8.

// File: rtl/osd_dot_pkg.sv
package osd_dot_pkg;
  localparam int SZ_W = 2;
  localparam int RT_W = 2;
  localparam int HS_W = SZ_W + 1;
  localparam int VL_W = SZ_W + 2;

  typedef struct packed {
    logic            src_osc;
    logic            cc;
    logic            err;
    logic [RT_W-1:0] ratio;
    logic [HS_W-1:0] hsize;
  } blk_cfg_t;

  function automatic logic [RT_W-1:0] f_ratio(input logic layer2, input logic cc,
                                               input logic [1:0] code, input logic div2);
    logic [RT_W-1:0] r;
    if (layer2) r = div2 ? RT_W'(2) : RT_W'(1);
    else begin
      case (code)
        2'd0:    r = RT_W'(1);
        2'd1:    r = RT_W'(2);
        default: r = cc ? RT_W'(2) : RT_W'(3);
      endcase
    end
    return r;
  endfunction

  function automatic logic f_err(input logic layer2, input logic cc, input logic [1:0] code);
    return !layer2 && cc && code[1];
  endfunction

  function automatic logic [HS_W-1:0] f_hsize(input logic layer2,
                                              input logic [2*SZ_W-1:0] s1,
                                              input logic [SZ_W-1:0] s2);
    logic [SZ_W-1:0] f;
    f = layer2 ? s2 : s1[SZ_W-1:0];
    return HS_W'(f) + HS_W'(1);
  endfunction

  function automatic logic [VL_W-1:0] f_vlim(input logic layer2,
                                             input logic [2*SZ_W-1:0] s1,
                                             input logic [SZ_W-1:0] s2,
                                             input logic biscan);
    logic [SZ_W-1:0] f;
    logic [VL_W-1:0] base;
    f    = layer2 ? s2 : s1[2*SZ_W-1:SZ_W];
    base = VL_W'(f) + VL_W'(1);
    return biscan ? (base << 1) : base;
  endfunction
endpackage

// File: rtl/osd_cfg_shadow.sv
module osd_cfg_shadow
  import osd_dot_pkg::*;
#(
  parameter int HPOS_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hsync,
  input  logic                 src_osc,
  input  logic                 cc_mode,
  input  logic                 layer2,
  input  logic [1:0]           prediv,
  input  logic [2*SZ_W-1:0]    size_l1,
  input  logic [SZ_W-1:0]      size_l2,
  input  logic                 l2_div2,
  input  logic                 biscan,
  input  logic [HPOS_W-1:0]    hstart,
  output blk_cfg_t             sh,
  output logic [HPOS_W-1:0]    hpos_sh,
  output logic [VL_W-1:0]      vlim_nx
);
  blk_cfg_t nx;

  always_comb begin
    nx.src_osc = src_osc;
    nx.cc      = cc_mode && !layer2;
    nx.err     = f_err(layer2, cc_mode, prediv);
    nx.ratio   = f_ratio(layer2, cc_mode, prediv, l2_div2);
    nx.hsize   = f_hsize(layer2, size_l1, size_l2);
  end

  assign vlim_nx = f_vlim(layer2, size_l1, size_l2, biscan);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '{src_osc: 1'b0, cc: 1'b0, err: 1'b0, ratio: RT_W'(1), hsize: HS_W'(1)};
      hpos_sh <= '0;
    end else if (hsync) begin
      sh      <= nx;
      hpos_sh <= hstart;
    end
  end

  // R7: closed-caption blocks never run at ratio 3
  a_r7_no_ratio3_in_cc: assert property (@(posedge clk) disable iff (!rst_n)
    sh.cc |-> sh.ratio != RT_W'(3));
  // R7: a flagged configuration falls back to ratio 2
  a_r7_err_means_ratio2: assert property (@(posedge clk) disable iff (!rst_n)
    sh.err |-> sh.ratio == RT_W'(2));
  // R8: shadow only moves after a sync cycle
  a_r8_shadow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hsync) |-> ($stable(sh) && $stable(hpos_sh)));
endmodule

// File: rtl/osd_prediv.sv
module osd_prediv
  import osd_dot_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            run,
  input  logic            src_en,
  input  logic [RT_W-1:0] ratio,
  output logic            tc_tick
);
  logic [RT_W-1:0] cnt;
  logic            at_end;

  assign at_end  = (cnt == ratio - RT_W'(1));
  assign tc_tick = run && src_en && !restart && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart)          cnt <= '0;
    else if (run && src_en)    cnt <= at_end ? '0 : cnt + RT_W'(1);
  end

  // R2: the phase counter stays below the active ratio
  a_r2_cnt_below_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> cnt < ratio);
endmodule

// File: rtl/osd_hdot.sv
module osd_hdot
  import osd_dot_pkg::*;
#(
  parameter int HPOS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              src_en,
  input  logic [HPOS_W-1:0] hpos,
  input  logic [HS_W-1:0]   hsize,
  input  logic              tc_tick,
  output logic              start_hit,
  output logic              armed,
  output logic              dot_stb,
  output logic              disp_active
);
  logic              line_seen;
  logic              started;
  logic [HPOS_W-1:0] hpos_cnt;
  logic [HS_W-1:0]   hcnt;
  logic              dot_due;

  assign start_hit = line_seen && !started && src_en && !hsync && (hpos_cnt == hpos);
  assign dot_due   = tc_tick && (!disp_active || hcnt == hsize - HS_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_seen   <= 1'b0;
      started     <= 1'b0;
      armed       <= 1'b0;
      hpos_cnt    <= '0;
      hcnt        <= '0;
      dot_stb     <= 1'b0;
      disp_active <= 1'b0;
    end else if (hsync) begin
      line_seen   <= 1'b1;
      started     <= 1'b0;
      armed       <= 1'b0;
      hpos_cnt    <= '0;
      hcnt        <= '0;
      dot_stb     <= 1'b0;
      disp_active <= 1'b0;
    end else begin
      if (src_en && !started && hpos_cnt != '1) hpos_cnt <= hpos_cnt + 1'b1;
      if (start_hit) begin
        started <= 1'b1;
        armed   <= 1'b1;
      end
      dot_stb <= dot_due;
      if (tc_tick) begin
        disp_active <= 1'b1;
        hcnt        <= dot_due ? '0 : hcnt + HS_W'(1);
      end
    end
  end

  // R3: TC periods only run once the start position was met
  a_r3_tick_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    tc_tick |-> started);
  // R4: a strobe only while the block is displaying
  a_r4_dot_only_active: assert property (@(posedge clk) disable iff (!rst_n)
    dot_stb |-> disp_active);
  // R4: wide dots give isolated strobes
  a_r4_dot_single: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_stb && hsize != HS_W'(1)) |=> !dot_stb);
  // R9: nothing is shown before the first sync after reset
  a_r9_quiet_before_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !line_seen |-> (!disp_active && !dot_stb));
  // R10: first strobe and active flag rise together
  a_r10_first_dot_with_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_active) |-> dot_stb);
  // R10: sync clears the active flag
  a_r10_sync_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> !disp_active);
endmodule

// File: rtl/osd_vdot.sv
module osd_vdot
  import osd_dot_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hsync,
  input  logic [VL_W-1:0] vlim,
  output logic            line_stb
);
  logic [VL_W-1:0] vcnt;
  logic            row_end;

  assign row_end = (vcnt >= vlim - VL_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt     <= '0;
      line_stb <= 1'b0;
    end else if (hsync) begin
      vcnt     <= row_end ? '0 : vcnt + VL_W'(1);
      line_stb <= row_end;
    end else begin
      line_stb <= 1'b0;
    end
  end

  // R5: row strobe only follows a sync
  a_r5_line_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb |-> $past(hsync));
  // R5: row counter never reaches the largest legal height
  a_r5_vcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    vcnt < VL_W'(2 * (1 << SZ_W)));
endmodule

// File: rtl/osd_dot_timing.sv
module osd_dot_timing
  import osd_dot_pkg::*;
#(
  parameter int HPOS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ds_clk_en,
  input  logic              osc_clk_en,
  input  logic              hsync,
  input  logic              cfg_src_osc,
  input  logic              cfg_cc_mode,
  input  logic              cfg_layer2,
  input  logic [1:0]        cfg_prediv,
  input  logic [3:0]        cfg_size_l1,
  input  logic [1:0]        cfg_size_l2,
  input  logic              cfg_l2_div2,
  input  logic              cfg_biscan,
  input  logic [HPOS_W-1:0] cfg_hstart,
  output logic              dot_stb,
  output logic              line_stb,
  output logic              disp_active,
  output logic              cfg_err
);
  blk_cfg_t          sh;
  logic [HPOS_W-1:0] hpos_sh;
  logic [VL_W-1:0]   vlim_nx;
  logic              src_en;
  logic              start_hit;
  logic              armed;
  logic              tc_tick;

  osd_cfg_shadow #(.HPOS_W(HPOS_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .hsync(hsync),
    .src_osc(cfg_src_osc), .cc_mode(cfg_cc_mode), .layer2(cfg_layer2),
    .prediv(cfg_prediv), .size_l1(cfg_size_l1), .size_l2(cfg_size_l2),
    .l2_div2(cfg_l2_div2), .biscan(cfg_biscan), .hstart(cfg_hstart),
    .sh(sh), .hpos_sh(hpos_sh), .vlim_nx(vlim_nx)
  );

  assign src_en  = sh.src_osc ? osc_clk_en : ds_clk_en;
  assign cfg_err = sh.err;

  osd_prediv u_prediv (
    .clk(clk), .rst_n(rst_n), .restart(hsync || start_hit), .run(armed),
    .src_en(src_en), .ratio(sh.ratio), .tc_tick(tc_tick)
  );

  osd_hdot #(.HPOS_W(HPOS_W)) u_hdot (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .src_en(src_en),
    .hpos(hpos_sh), .hsize(sh.hsize), .tc_tick(tc_tick),
    .start_hit(start_hit), .armed(armed), .dot_stb(dot_stb),
    .disp_active(disp_active)
  );

  osd_vdot u_vdot (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vlim(vlim_nx), .line_stb(line_stb)
  );

  // R1: the active source enable is the only pace for TC periods
  a_r1_tick_from_chosen: assert property (@(posedge clk) disable iff (!rst_n)
    tc_tick |-> (sh.src_osc ? osc_clk_en : ds_clk_en));
endmodule

// File: tb/osd_dot_timing_tb_top.sv
`timescale 1ns/1ps
module osd_dot_timing_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ds_clk_en = 0, osc_clk_en = 0, hsync = 0;
  logic cfg_src_osc = 0, cfg_cc_mode = 0, cfg_layer2 = 0, cfg_l2_div2 = 0, cfg_biscan = 0;
  logic [1:0] cfg_prediv = 0, cfg_size_l2 = 0;
  logic [3:0] cfg_size_l1 = 0;
  logic [7:0] cfg_hstart = 0;
  logic dot_stb, line_stb, disp_active, cfg_err;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int vrow = 0;
  bit done = 0;
  int exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  osd_dot_timing dut_i (
    .clk(clk), .rst_n(rst_n), .ds_clk_en(ds_clk_en), .osc_clk_en(osc_clk_en),
    .hsync(hsync), .cfg_src_osc(cfg_src_osc), .cfg_cc_mode(cfg_cc_mode),
    .cfg_layer2(cfg_layer2), .cfg_prediv(cfg_prediv), .cfg_size_l1(cfg_size_l1),
    .cfg_size_l2(cfg_size_l2), .cfg_l2_div2(cfg_l2_div2), .cfg_biscan(cfg_biscan),
    .cfg_hstart(cfg_hstart), .dot_stb(dot_stb), .line_stb(line_stb),
    .disp_active(disp_active), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: every dot strobe must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && dot_stb) begin
      if (exp_q.size() == 0) chk("R1/R3/R4/R9 unexpected dot at cycle", cyc, -1);
      else chk("R3/R4 dot strobe cycle", cyc, exp_q.pop_front());
    end
  end

  // driver: one scan line, expected dots pushed before the line runs
  task automatic run_line(input bit osc, input bit cc, input bit l2, input bit div2,
                          input bit bis, input logic [1:0] pdc, input logic [3:0] s1,
                          input logic [1:0] s2, input int hp, input int pa, input int pb,
                          input int len, input bit alt);
    int rt, hs, vl, per, k0, eidx, tcs;
    bit err_m, row_m;
    // R2/R6/R7 ratio; R4/R6 width; R5/R6 height
    if (l2) rt = div2 ? 2 : 1;
    else if (pdc == 2'd0) rt = 1;
    else if (pdc == 2'd1) rt = 2;
    else rt = cc ? 2 : 3;
    err_m = !l2 && cc && (pdc >= 2);
    hs = l2 ? s2 + 1 : s1[1:0] + 1;
    vl = (l2 ? s2 + 1 : s1[3:2] + 1) * (bis ? 2 : 1);
    row_m = (vrow >= vl - 1);
    vrow = row_m ? 0 : vrow + 1;
    per = osc ? pb : pa;
    @(negedge clk);
    cfg_src_osc = osc; cfg_cc_mode = cc; cfg_layer2 = l2; cfg_l2_div2 = div2;
    cfg_biscan = bis; cfg_prediv = pdc; cfg_size_l1 = s1; cfg_size_l2 = s2;
    cfg_hstart = 8'(hp);
    hsync = 1; ds_clk_en = 0; osc_clk_en = 0;
    k0 = cyc;
    eidx = 0; tcs = 0;
    for (int j = 1; j < len; j++) begin
      if (j < len - 3 && (j % per) == 0) begin
        if (eidx > hp && ((eidx - hp) % rt) == 0) begin
          tcs++;
          if (((tcs - 1) % hs) == 0) exp_q.push_back(k0 + j + 1);
        end
        eidx++;
      end
    end
    for (int j = 1; j < len; j++) begin
      @(negedge clk);
      if (j == 1) begin
        chk("R5 line_stb after sync", line_stb, row_m);
        chk("R7 cfg_err", cfg_err, err_m);
        chk("R10 active cleared after sync", disp_active, 0);
      end
      hsync = 0;
      ds_clk_en  = (j < len - 3) && ((j % pa) == 0);
      osc_clk_en = (j < len - 3) && ((j % pb) == 0);
      if (alt && j == 2) begin // R8: mid-line changes are ignored
        cfg_size_l1 = ~s1; cfg_hstart = 8'(hp + 5); cfg_prediv = pdc + 2'd1;
        cfg_src_osc = ~osc; cfg_layer2 = ~l2;
      end
      if (j == len - 1) chk("R10 active at end of line", disp_active, tcs > 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset dot_stb", dot_stb, 0);
    chk("R9 reset line_stb", line_stb, 0);
    chk("R9 reset disp_active", disp_active, 0);
    chk("R9 reset cfg_err", cfg_err, 0);
    rst_n = 1;
    // R9: enables before the first sync start nothing
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      ds_clk_en = 1; osc_clk_en = 1;
    end
    @(negedge clk);
    chk("R9 no display before first sync", disp_active, 0);
    //        osc cc l2 d2 bis pdc  s1     s2  hp pa pb len alt
    run_line(0, 0, 0, 0, 0, 2'd0, 4'h0, 2'd0, 3, 1, 3, 40, 0); // R2 ratio 1
    run_line(0, 0, 0, 0, 0, 2'd1, 4'h2, 2'd0, 5, 2, 1, 60, 0); // R2/R4
    run_line(1, 0, 0, 0, 0, 2'd2, 4'h1, 2'd0, 2, 1, 3, 60, 0); // R1 osc
    run_line(0, 0, 0, 0, 0, 2'd3, 4'h3, 2'd0, 0, 1, 2, 60, 0); // R2 code 3
    run_line(0, 1, 0, 0, 0, 2'd2, 4'h1, 2'd0, 4, 1, 1, 50, 0); // R7
    run_line(0, 1, 0, 0, 0, 2'd1, 4'h0, 2'd0, 1, 1, 1, 30, 0); // R7 legal
    run_line(0, 0, 1, 1, 0, 2'd2, 4'h0, 2'd2, 3, 1, 2, 50, 0); // R6
    run_line(1, 0, 0, 0, 0, 2'd1, 4'h1, 2'd0, 2, 2, 1, 50, 1); // R8
    run_line(0, 0, 0, 0, 0, 2'd0, 4'h1, 2'd0, 50, 1, 1, 30, 0); // R3 start never met
    for (int n = 0; n < 7; n++)
      run_line(0, 0, 0, 0, 0, 2'd0, 4'h8, 2'd0, 1, 1, 1, 20, 0); // R5 height 3
    for (int n = 0; n < 7; n++)
      run_line(0, 0, 0, 0, 1, 2'd0, 4'h8, 2'd0, 1, 1, 1, 20, 0); // R5 bi-scan 6
    for (int n = 0; n < 3; n++)
      run_line(1, 0, 1, 0, 0, 2'd0, 4'h0, 2'd1, 0, 1, 1, 20, 0); // R6 height 2
    repeat (4) @(negedge clk);
    chk("R4 all expected dots seen", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule